// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the target side of a 16-bit bus on which one set of shared lines carries first an address and then data. A host processor frames each access with a chip select. It marks the address cycle with a low address-valid strobe, then moves one 32-bit word as two 16-bit data phases. The block samples every bus input on the rising edge of the bus clock, because the host changes its signals on the falling edge. It turns each access into a transaction on a simple internal register-file port.

On a write, the block keeps the address, then the low half, then the high half, and gives the register file a one-cycle write strobe. On a read, it presents the address to the register file and drives the returned word back onto the shared lines, one half at a time, while output enable is low. The host may stretch the first data phase with a wait state. A `wait_states` input (1 or 2) tells the block how many bus clocks that first phase lasts, so a repeated low half is never taken for the high half.

Top module: `muxbus_target`

## Requirements
- R1: While reset is active, and after it is released until the first access, `rf_we` is 0 and the block does not drive `ad`.
- R2: The address is taken from `ad` on each rising edge where `cs_n` and `adv_n` are both low. If `adv_n` stays low for several cycles, the value from the last such edge wins. `rf_addr` then holds that value until the next address cycle.
- R3: The first data phase starts on the first rising edge with `cs_n` low and `adv_n` high, and lasts `wait_states` (1 or 2) bus clocks. Only its first cycle supplies the low half. The high half is taken on the edge that follows the first data phase.
- R4: After the high half is sampled on a write, `rf_we` is 1 for exactly one clock cycle, starting just after that edge. During that cycle `rf_wdata` = {high half, low half} and `rf_addr` is the captured address.
- R5: A strobe is produced only if `we_n` was sampled low on at least one rising edge of the access, counting from the address cycle. This includes a write enable that the host asserts late, in the high-half cycle only.
- R6: While `cs_n` and `oe_n` are both low, the block drives `ad` with `rf_rdata[15:0]` during the first data phase, including its wait cycle, and with `rf_rdata[31:16]` from the second data phase on.
- R7: When `cs_n` or `oe_n` is high, the block leaves `ad` undriven.
- R8: An access in which `we_n` stays high produces no `rf_we` pulse.
- R9: If `cs_n` goes high before the high half is sampled, the access is dropped without a strobe, and the next access proceeds normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock; inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, frames an access |
| adv_n | input | 1 | Address-valid strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wait_states | input | 2 | Length of the first data phase in bus clocks (1 or 2) |
| ad | inout | 16 | Shared address/data lines |
| rf_addr | output | 16 | Register-file address |
| rf_wdata | output | 32 | Register-file write data |
| rf_we | output | 1 | Register-file write strobe, one cycle |
| rf_rdata | input | 32 | Register-file read data, combinational from `rf_addr` |

## Verification
The hardest case to reach is a stretched first data phase in which the low half is repeated while the host write enable behaves unusually. Examples are a write enable that comes only in the high-half cycle, or an address-valid strobe held for two cycles with a different address in each. These combinations only show up when several timing options are chosen together. The stimulus mixes directed accesses for each of these corners with seeded random accesses. The random accesses draw the wait count, late write enable, a held address-valid strobe and early chip-select release independently. Every read is then checked against a shadow copy of all the words written so far.

// File: rtl/muxbus_pkg.sv
`timescale 1ns/1ps
package muxbus_pkg;
  // Position of the target within one access
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // no access, or waiting for chip select to drop
    PH_LO   = 2'd1,  // first data phase (low half, may be stretched)
    PH_HI   = 2'd2,  // second data phase (high half)
    PH_DONE = 2'd3   // word complete, waiting for chip select to rise
  } phase_e;
endpackage

// File: rtl/mb_phase_fsm.sv
`timescale 1ns/1ps
module mb_phase_fsm
  import muxbus_pkg::*;
#(
  parameter int MAX_WAIT = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic                         adv_n,
  input  logic [$clog2(MAX_WAIT+1)-1:0] wait_states,
  output phase_e                       phase,
  output logic                         addr_load,
  output logic                         lo_load,
  output logic                         hi_load
);
  localparam int WAIT_W = $clog2(MAX_WAIT + 1);

  phase_e             phase_q, phase_d;
  logic [WAIT_W-1:0]  cnt_q, cnt_d;
  logic [WAIT_W:0]    cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    addr_load = 1'b0;
    lo_load   = 1'b0;
    hi_load   = 1'b0;
    if (cs_n) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (!adv_n) begin
      addr_load = 1'b1;
      phase_d   = PH_LO;
      cnt_d     = '0;
    end else begin
      unique case (phase_q)
        PH_LO: begin
          lo_load = (cnt_q == '0);
          if (cnt_inc >= {1'b0, wait_states}) begin
            phase_d = PH_HI;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_inc[WAIT_W-1:0];
          end
        end
        PH_HI: begin
          hi_load = 1'b1;
          phase_d = PH_DONE;
        end
        default: phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;

  // R9
  cs_release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase_q == PH_IDLE));

  // R3
  done_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE) |-> ($past(phase_q) == PH_HI || $past(phase_q) == PH_DONE));

  // R3
  wait_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < MAX_WAIT);
endmodule

// File: rtl/mb_capture.sv
`timescale 1ns/1ps
module mb_capture
  import muxbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   ad_in,
  input  logic                cs_n,
  input  logic                we_n,
  input  phase_e              phase,
  input  logic                addr_load,
  input  logic                lo_load,
  input  logic                hi_load,
  output logic [DATA_W-1:0]   rf_addr,
  output logic [2*DATA_W-1:0] rf_wdata,
  output logic                rf_we
);
  logic [DATA_W-1:0] addr_q, lo_q, hi_q;
  logic              we_seen_q, we_seen_d;
  logic              strobe_q, strobe_d;

  always_comb begin
    we_seen_d = we_seen_q;
    if (cs_n)           we_seen_d = 1'b0;
    else if (addr_load) we_seen_d = !we_n;
    else if (!we_n)     we_seen_d = 1'b1;
    strobe_d = hi_load && (we_seen_q || !we_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      we_seen_q <= 1'b0;
      strobe_q  <= 1'b0;
    end else begin
      if (addr_load) addr_q <= ad_in;
      if (lo_load)   lo_q   <= ad_in;
      if (hi_load)   hi_q   <= ad_in;
      we_seen_q <= we_seen_d;
      strobe_q  <= strobe_d;
    end
  end

  assign rf_addr  = addr_q;
  assign rf_wdata = {hi_q, lo_q};
  assign rf_we    = strobe_q;

  // R4
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  // R4
  strobe_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (phase == PH_DONE || phase == PH_IDLE));
endmodule

// File: rtl/mb_rd_mux.sv
`timescale 1ns/1ps
module mb_rd_mux
  import muxbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                cs_n,
  input  logic                oe_n,
  input  phase_e              phase,
  input  logic [2*DATA_W-1:0] rf_rdata,
  output logic                drv_en,
  output logic [DATA_W-1:0]   drv_data
);
  logic sel_hi;

  always_comb begin
    drv_en   = !cs_n && !oe_n;
    sel_hi   = (phase == PH_HI) || (phase == PH_DONE);
    drv_data = sel_hi ? rf_rdata[2*DATA_W-1:DATA_W] : rf_rdata[DATA_W-1:0];
  end
endmodule

// File: rtl/muxbus_target.sv
`timescale 1ns/1ps
module muxbus_target
  import muxbus_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MAX_WAIT = 2,
  localparam int WAIT_W  = $clog2(MAX_WAIT + 1),
  localparam int WORD_W  = 2 * DATA_W
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [WAIT_W-1:0] wait_states,
  inout  wire  [DATA_W-1:0] ad,
  output logic [DATA_W-1:0] rf_addr,
  output logic [WORD_W-1:0] rf_wdata,
  output logic              rf_we,
  input  logic [WORD_W-1:0] rf_rdata
);
  // Reset asserted asynchronously, released on the bus clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  phase_e            phase;
  logic              addr_load, lo_load, hi_load;
  logic              drv_en;
  logic [DATA_W-1:0] drv_data;
  logic [DATA_W-1:0] ad_in;

  assign ad_in = ad;
  assign ad    = drv_en ? drv_data : {DATA_W{1'bz}};

  mb_phase_fsm #(.MAX_WAIT(MAX_WAIT)) u_fsm (
    .clk         (bclk),
    .rst_n       (rst_int_n),
    .cs_n        (cs_n),
    .adv_n       (adv_n),
    .wait_states (wait_states),
    .phase       (phase),
    .addr_load   (addr_load),
    .lo_load     (lo_load),
    .hi_load     (hi_load)
  );

  mb_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (bclk),
    .rst_n     (rst_int_n),
    .ad_in     (ad_in),
    .cs_n      (cs_n),
    .we_n      (we_n),
    .phase     (phase),
    .addr_load (addr_load),
    .lo_load   (lo_load),
    .hi_load   (hi_load),
    .rf_addr   (rf_addr),
    .rf_wdata  (rf_wdata),
    .rf_we     (rf_we)
  );

  mb_rd_mux #(.DATA_W(DATA_W)) u_mux (
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .phase    (phase),
    .rf_rdata (rf_rdata),
    .drv_en   (drv_en),
    .drv_data (drv_data)
  );

  // R8
  no_strobe_idle_chk: assert property (@(posedge bclk) disable iff (!rst_int_n)
    (phase == PH_IDLE && $past(phase) == PH_IDLE) |-> !rf_we);

  // R2
  addr_hold_chk: assert property (@(posedge bclk) disable iff (!rst_int_n)
    (phase != PH_LO) |-> $stable(rf_addr));
endmodule

// File: tb/tb_muxbus_target.sv
`timescale 1ns/1ps
module tb_muxbus_target;
  logic        bclk = 1'b0;
  logic        rst_n;
  logic        cs_n, adv_n, we_n, oe_n;
  logic [1:0]  wait_states;
  wire  [15:0] ad;
  logic [15:0] rf_addr;
  logic [31:0] rf_wdata;
  logic        rf_we;
  logic [31:0] rf_rdata;

  logic        host_en;
  logic [15:0] host_ad;
  assign ad = host_en ? host_ad : 16'hzzzz;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] rf_mem [16];
  logic [31:0] shadow [16];

  always #2 bclk = ~bclk;

  assign rf_rdata = rf_mem[rf_addr[3:0]];
  always_ff @(posedge bclk) if (rf_we) rf_mem[rf_addr[3:0]] <= rf_wdata;

  muxbus_target dut (
    .bclk(bclk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
    .oe_n(oe_n), .wait_states(wait_states), .ad(ad), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] half(input logic [31:0] w, input bit hi);
    return hi ? w[31:16] : w[15:0];
  endfunction

  task automatic idle_bus();
    cs_n = 1; adv_n = 1; we_n = 1; oe_n = 1; host_en = 0; host_ad = '0;
  endtask

  // Write access: ws = first-phase length, late = WE only in high-half cycle,
  // adv2 = address strobe held two cycles (second address wins), abort = CS rises early
  task automatic do_write(input logic [15:0] addr, input logic [31:0] data, input int ws,
                          input bit late, input bit adv2, input bit abort);
    logic [15:0] a_first;
    a_first = adv2 ? ~addr : addr;
    @(negedge bclk);
    wait_states = 2'(ws);
    cs_n = 0; adv_n = 0; host_en = 1; host_ad = a_first; we_n = late;
    if (adv2) begin
      @(negedge bclk); host_ad = addr;
    end
    @(negedge bclk); adv_n = 1; host_ad = data[15:0];
    for (int i = 1; i < ws; i++) @(negedge bclk);
    if (abort) begin
      @(negedge bclk); idle_bus();
      chk(rf_we == 1'b0, "R9 no strobe on abort", {31'd0, rf_we}, 32'd0);
      @(negedge bclk);
      chk(rf_we == 1'b0, "R9 no strobe on abort (next)", {31'd0, rf_we}, 32'd0);
    end else begin
      @(negedge bclk); host_ad = data[31:16]; we_n = 0;
      @(negedge bclk); idle_bus();
      chk(rf_we == 1'b1, "R4/R5 strobe present", {31'd0, rf_we}, 32'd1);
      chk(rf_addr == addr, "R2 write address", {16'd0, rf_addr}, {16'd0, addr});
      chk(rf_wdata == data, "R3/R4 write word", rf_wdata, data);
      shadow[addr[3:0]] = data;
      @(negedge bclk);
      chk(rf_we == 1'b0, "R4 strobe one cycle", {31'd0, rf_we}, 32'd0);
    end
  endtask

  task automatic do_read(input logic [15:0] addr, input int ws);
    logic [31:0] exp;
    exp = shadow[addr[3:0]];
    @(negedge bclk);
    wait_states = 2'(ws);
    cs_n = 0; adv_n = 0; host_en = 1; host_ad = addr; we_n = 1; oe_n = 1;
    @(negedge bclk); adv_n = 1; host_en = 0; oe_n = 0;
    for (int i = 0; i < ws; i++) begin
      #1;
      chk(ad == half(exp, 0), "R6 read low half", {16'd0, ad}, {16'd0, half(exp, 0)});
      chk(rf_we == 1'b0, "R8 no strobe on read", {31'd0, rf_we}, 32'd0);
      @(negedge bclk);
    end
    #1;
    chk(ad == half(exp, 1), "R6 read high half", {16'd0, ad}, {16'd0, half(exp, 1)});
    @(negedge bclk); idle_bus();
    #1;
    chk(rf_we == 1'b0, "R8 no strobe after read", {31'd0, rf_we}, 32'd0);
  endtask

  task automatic release_test();
    @(negedge bclk);
    cs_n = 0; adv_n = 0; host_en = 1; host_ad = 16'h0003; we_n = 1; oe_n = 1;
    @(negedge bclk); adv_n = 1; host_ad = 16'hC3A5;
    #1;
    chk(ad == 16'hC3A5, "R7 released with oe_n high", {16'd0, ad}, 32'h0000C3A5);
    @(negedge bclk); cs_n = 1; oe_n = 0; host_ad = 16'h3C5A;
    #1;
    chk(ad == 16'h3C5A, "R7 released with cs_n high", {16'd0, ad}, 32'h00003C5A);
    @(negedge bclk); idle_bus();
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    for (int i = 0; i < 16; i++) begin rf_mem[i] = '0; shadow[i] = '0; end
    idle_bus();
    wait_states = 2'd1;
    rst_n = 0;
    repeat (3) @(negedge bclk);
    chk(rf_we == 1'b0, "R1 reset strobe low", {31'd0, rf_we}, 32'd0);
    host_en = 1; host_ad = 16'hA55A;
    #1;
    chk(ad == 16'hA55A, "R1 bus released in reset", {16'd0, ad}, 32'h0000A55A);
    host_en = 0;
    @(negedge bclk); rst_n = 1;
    repeat (4) @(negedge bclk);
    chk(rf_we == 1'b0, "R1 strobe low after reset", {31'd0, rf_we}, 32'd0);

    // Directed corners
    do_write(16'h0001, 32'h1234_5678, 1, 0, 0, 0);
    do_write(16'h0002, 32'hCAFE_F00D, 2, 0, 0, 0);   // R3 repeated low half
    do_write(16'h0004, 32'h0BAD_BEEF, 2, 1, 0, 0);   // R5 late write enable
    do_write(16'h0005, 32'h5555_AAAA, 1, 0, 1, 0);   // R2 held address strobe
    do_write(16'h0006, 32'hDEAD_0001, 1, 0, 0, 1);   // R9 abort
    do_write(16'h0006, 32'h7777_1111, 2, 0, 0, 0);   // R9 next access clean
    do_read(16'h0001, 1);
    do_read(16'h0002, 2);
    do_read(16'h0004, 1);
    do_read(16'h0005, 2);
    do_read(16'h0006, 1);
    release_test();

    // Seeded random mix
    for (int n = 0; n < 300; n++) begin
      logic [15:0] a;
      int          ws;
      int          kind;
      a    = 16'($urandom);
      ws   = 1 + int'($urandom % 2);
      kind = int'($urandom % 8);
      if (kind < 4)
        do_write(a, $urandom, ws, ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 6) == 0);
      else
        do_read(a, ws);
    end
    for (int i = 0; i < 16; i++) do_read(16'(i), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule